// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns activity on an 8-pin general-purpose port into a single interrupt line. It watches the synchronised input pin values. Only pins that the port block has configured as inputs are considered. Each pin has three settings that choose how it is watched: a sense bit, a both-edges bit and an event bit. Together they pick falling-edge, rising-edge, any-edge, high-level or low-level detection.

A detection sets that pin's bit in a raw status register. The raw status is gated by a per-pin mask to form a masked status, and the interrupt output is high whenever any masked bit is set. Software reads the status through a small register window and clears latched bits by writing ones to a clear register. The port block keeps the data register and the pin synchroniser. It presents the pin values and direction bits to this block.

Register accesses are single-cycle. A write takes effect at the clock edge. A read returns data combinationally from the address. In every register, bit i refers to pin i.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, the sense, both-edges, event, mask, raw status and masked status registers all read 0, and `irq` is low.
- R2: The sense (0x404), both-edges (0x408), event (0x40C) and mask (0x410) registers are written and read back at their offsets. The raw status reads at 0x414 and the masked status at 0x418. Bit i of each register belongs to pin i. Any other offset reads 0.
- R3: A pin whose direction bit is 1 (output) never sets its raw status bit, whatever its value does.
- R4: Edge detection compares each pin's current sample with its sample at the previous clock. When the sense bit is 0 and the both-edges bit is 1, any change of that pin sets its raw status bit at the next clock edge.
- R5: When the sense bit is 0 and the both-edges bit is 0, a change sets the status bit only if the new level equals the event bit. Event 1 selects rising edges and event 0 selects falling edges; a change in the other direction has no effect.
- R6: When the sense bit is 1 (level), the raw status bit is set on every clock while the pin's level equals the event bit.
- R7: Writing to 0x41C clears each raw status bit written as 1 and leaves bits written as 0 unchanged. The clear wins over a detection in the same cycle. A still-active level pin sets its bit again on the following clock.
- R8: The masked status equals raw status AND mask, and `irq` is high exactly when any masked status bit is 1.
- R9: Writes to the read-only status offsets (0x414, 0x418) and to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPINS | Synchronised pin levels from the port block |
| pin_dir | input | NPINS | Direction per pin, 1 = output |
| bus_addr | input | AW | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for `bus_addr`, combinational |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `pin_in` and `pin_dir` are already synchronous to `clk` and hold steady between edges. They also assume that a write lasts exactly one cycle with a stable address. The bench meets these assumptions by changing pins, direction and bus signals only on the falling clock edge. It never leaves the write strobe high for more than one cycle. The pins are held low through reset, so the first sample after reset does not make a spurious edge.

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 8,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] pin_dir,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             irq
);
  localparam logic [AW-1:0] A_SENSE = AW'(12'h404);
  localparam logic [AW-1:0] A_BOTH  = AW'(12'h408);
  localparam logic [AW-1:0] A_EVENT = AW'(12'h40C);
  localparam logic [AW-1:0] A_MASK  = AW'(12'h410);
  localparam logic [AW-1:0] A_RAW   = AW'(12'h414);
  localparam logic [AW-1:0] A_MSK   = AW'(12'h418);
  localparam logic [AW-1:0] A_CLR   = AW'(12'h41C);

  logic [NPINS-1:0] sense_q, both_q, event_q, mask_q, raw_q, prev_q;
  logic [NPINS-1:0] match, changed, hit, clr;

  assign match   = ~(pin_in ^ event_q);
  assign changed = pin_in ^ prev_q;
  assign hit     = ~pin_dir & ((sense_q & match) |
                               (~sense_q & changed & (both_q | match)));
  assign clr     = (bus_wr && bus_addr == A_CLR) ? bus_wdata : '0;
  assign irq     = |(raw_q & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sense_q <= '0;
      both_q  <= '0;
      event_q <= '0;
      mask_q  <= '0;
      raw_q   <= '0;
      prev_q  <= '0;
    end else begin
      prev_q <= pin_in;
      raw_q  <= (raw_q | hit) & ~clr;
      if (bus_wr) begin
        case (bus_addr)
          A_SENSE: sense_q <= bus_wdata;
          A_BOTH:  both_q  <= bus_wdata;
          A_EVENT: event_q <= bus_wdata;
          A_MASK:  mask_q  <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_SENSE: bus_rdata = sense_q;
      A_BOTH:  bus_rdata = both_q;
      A_EVENT: bus_rdata = event_q;
      A_MASK:  bus_rdata = mask_q;
      A_RAW:   bus_rdata = raw_q;
      A_MSK:   bus_rdata = raw_q & mask_q;
      default: bus_rdata = '0;
    endcase
  end

  // R3
  out_pin_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & $past(pin_dir)) == '0));

  // R4
  edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(sense_q) &
               ~($past(pin_in) ^ $past(prev_q))) == '0));

  // R6
  level_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_addr == A_CLR) |=>
      (($past(sense_q & ~pin_dir & ~(pin_in ^ event_q)) & ~raw_q) == '0));

  // R7
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CLR) |=> ((raw_q & $past(bus_wdata)) == '0));

  // R8
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
  localparam int N = 8;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] pin_in = '0, pin_dir = '0, bus_wdata = '0, bus_rdata;
  logic [AW-1:0] bus_addr = '0;
  logic bus_wr = 0, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  bit [N-1:0] m_sense, m_both, m_ev, m_mask, m_raw, m_prev;

  always #2 clk = ~clk;

  gpio_irq_detect #(.NPINS(N), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq));

  always @(posedge clk) begin
    bit [N-1:0] s;
    if (!rst_n) begin
      m_sense = 0; m_both = 0; m_ev = 0; m_mask = 0; m_raw = 0; m_prev = 0;
    end else begin
      s = 0;
      for (int i = 0; i < N; i++) begin
        if (pin_dir[i] == 0) begin
          if (m_sense[i]) begin
            if (pin_in[i] == m_ev[i]) s[i] = 1;
          end else if (pin_in[i] != m_prev[i]) begin
            if (m_both[i] || pin_in[i] == m_ev[i]) s[i] = 1;
          end
        end
      end
      m_raw = m_raw | s;
      if (bus_wr) begin
        if (bus_addr == 12'h41C) m_raw = m_raw & ~bus_wdata;
        if (bus_addr == 12'h404) m_sense = bus_wdata;
        if (bus_addr == 12'h408) m_both = bus_wdata;
        if (bus_addr == 12'h40C) m_ev = bus_wdata;
        if (bus_addr == 12'h410) m_mask = bus_wdata;
      end
      m_prev = pin_in;
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      checks++;
      if (irq !== ((m_raw & m_mask) != 0)) begin
        errors++;
        $display("FAIL R8 irq: actual %0b expected %0b", irq, (m_raw & m_mask) != 0);
      end
    end
  end

  function automatic bit [N-1:0] mdl_rd(input bit [AW-1:0] a);
    case (a)
      12'h404: return m_sense;
      12'h408: return m_both;
      12'h40C: return m_ev;
      12'h410: return m_mask;
      12'h414: return m_raw;
      12'h418: return m_raw & m_mask;
      default: return 0;
    endcase
  endfunction

  task automatic wr(input bit [AW-1:0] a, input bit [N-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input bit [AW-1:0] a, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== mdl_rd(a)) begin
      errors++;
      $display("FAIL %s read %h: actual %h expected %h", tag, a, bus_rdata, mdl_rd(a));
    end
  endtask

  task automatic pins(input bit [N-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  initial begin
    #800000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    checks++;
    if (irq !== 0) begin errors++; $display("FAIL R1 irq: actual %b expected 0", irq); end
    // R1 reset state
    for (int a = 12'h404; a <= 12'h418; a += 4) rd(a[AW-1:0], "R1");
    pin_dir = 8'hC0;
    // R2 configuration
    wr(12'h404, 8'h30); rd(12'h404, "R2");
    wr(12'h408, 8'hC3); rd(12'h408, "R2");
    wr(12'h40C, 8'h14); rd(12'h40C, "R2");
    rd(12'h420, "R2");
    // R6 pin5 low-level active immediately
    rd(12'h414, "R6");
    wr(12'h410, 8'hFF); rd(12'h418, "R8");
    // R7 clear with level still active, then re-set
    @(negedge clk); bus_addr = 12'h41C; bus_wdata = 8'hFF; bus_wr = 1;
    @(negedge clk); bus_wr = 0; bus_addr = 12'h414; #1;
    checks++;
    if (bus_rdata[5] !== 1'b0) begin errors++; $display("FAIL R7 clear: actual %b expected 0", bus_rdata[5]); end
    rd(12'h414, "R6");
    pins(8'h20); wr(12'h41C, 8'hFF); rd(12'h414, "R7");
    // R4 both-edge pins 0 and 1
    pins(8'h21); rd(12'h414, "R4"); pins(8'h20); rd(12'h414, "R4");
    wr(12'h41C, 8'h01); rd(12'h414, "R7");
    pins(8'h22); rd(12'h414, "R4"); wr(12'h41C, 8'hFF);
    pins(8'h20); rd(12'h414, "R4"); wr(12'h41C, 8'hFF);
    // R5 pin2 rising, pin3 falling
    pins(8'h24); rd(12'h414, "R5"); wr(12'h41C, 8'hFF);
    pins(8'h20); rd(12'h414, "R5");
    pins(8'h28); rd(12'h414, "R5");
    pins(8'h20); rd(12'h414, "R5"); wr(12'h41C, 8'hFF); rd(12'h418, "R8");
    // R3 output pins toggled
    pins(8'hE0); rd(12'h414, "R3"); pins(8'h20); rd(12'h414, "R3");
    // R6 pin4 high level
    pins(8'h30); rd(12'h414, "R6"); wr(12'h41C, 8'h10); rd(12'h414, "R6");
    pins(8'h20); wr(12'h41C, 8'hFF); rd(12'h414, "R6");
    // R8 partial mask
    pins(8'h21); wr(12'h410, 8'h02); rd(12'h418, "R8");
    wr(12'h410, 8'h01); rd(12'h418, "R8");
    // R9 read-only and unmapped writes
    wr(12'h414, 8'hFF); rd(12'h414, "R9");
    wr(12'h418, 8'h00); rd(12'h418, "R9");
    wr(12'h500, 8'hFF); rd(12'h404, "R9"); rd(12'h410, "R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule